// File: doc/BRIEF.md
# Character Cell Block Engine

This engine edits a text-mode frame buffer in which every screen position is a 16-bit character cell: a glyph code in the low byte and a colour attribute in the high byte. It runs three commands on a rectangle of cells. Fill stamps one glyph and one attribute into every cell. String takes glyph codes from a byte stream and places them cell by cell under a shared attribute. Copy moves a rectangle of whole cells from one place to another, and picks its walk direction so that overlapping source and destination areas still give the right result.

A command is set up on plain input pins and launched with a one-cycle `cmd_start` while the engine is idle. `busy` stays high while the command runs, and `done` pulses once when the final memory write has been accepted. The engine reaches memory through a 16-bit, byte-addressed request port with a valid/ready handshake. Read data returns exactly one cycle after a read is accepted. The glyph stream for String uses valid/ready. A byte is taken only on a cycle where both `str_valid` and `str_ready` are high. The engine raises `str_ready` only when it wants the next glyph, and the source may hold `str_valid` low for as long as it likes. When `mem_ready` is low, the engine holds its request unchanged, and that back-pressure also holds off the next stream byte.

Top module: `cellblit_top`

## Requirements
- R1: After reset, `busy`, `done`, `mem_valid` and `str_ready` are all low.
- R2: Cell (x, y) lives at byte address `cmd_base + x*S + y*S*(cmd_vwidth/8)`, with S = 2 << `cmd_shift`. The written word holds the glyph in bits 7:0 and the attribute in bits 15:8. The attribute is `{cmd_bg[3:0], cmd_fg[3:0]}`, so the upper nibbles of those inputs are ignored.
- R3: Fill (`cmd_op` = 0) writes `cmd_glyph` and the attribute to every cell of the `cmd_width` x `cmd_height` rectangle at (`cmd_dx`, `cmd_dy`), and to no other cell.
- R4: String (`cmd_op` = 1) writes stream glyphs in row-major order across the rectangle at (`cmd_dx`, `cmd_dy`). It stops after `cmd_len` cells or when the rectangle is full, whichever comes first. A `cmd_len` of 0 makes no writes.
- R5: The glyph stream is consumed only by String commands, and exactly one byte is taken for each cell written.
- R6: Copy (`cmd_op` = 2) from (`cmd_sx`, `cmd_sy`) to (`cmd_dx`, `cmd_dy`) walks forward from the top-left cell when the source row is below the destination row, or when the rows are equal and the source column is to the right. The result equals a copy taken from a snapshot made before the command.
- R7: In every other case the copy walks backward from the bottom-right cell with negated steps, and it also matches the snapshot result when the rectangles overlap.
- R8: A copy issues exactly one read and one write per cell, and never issues a write before the read data for that cell has returned. Fill and String never read.
- R9: `cmd_start` is ignored while `busy` is high. `done` is high for exactly one cycle, after the last write and with `busy` already low.
- R10: A zero width, a zero height or `cmd_op` = 3 finishes with a `done` pulse and no memory access.
- R11: While `mem_valid` is high and `mem_ready` is low, the address, write flag and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Launch pulse, taken only while idle |
| cmd_op | input | 2 | 0 fill, 1 string, 2 copy, 3 no operation |
| cmd_shift | input | SW | Cell stride exponent, stride = 2 << shift bytes |
| cmd_vwidth | input | VW | Virtual line width in pixels (8 pixels per cell) |
| cmd_base | input | AW | Byte address of cell (0,0) |
| cmd_sx | input | CW | Copy source column |
| cmd_sy | input | CW | Copy source row |
| cmd_dx | input | CW | Destination column |
| cmd_dy | input | CW | Destination row |
| cmd_width | input | CW | Rectangle width in cells |
| cmd_height | input | CW | Rectangle height in cells |
| cmd_glyph | input | 8 | Fill glyph |
| cmd_fg | input | 8 | Foreground colour, low nibble used |
| cmd_bg | input | 8 | Background colour, low nibble used |
| cmd_len | input | LW | String length in cells |
| str_valid | input | 1 | Glyph stream valid |
| str_ready | output | 1 | Glyph stream ready |
| str_data | input | 8 | Glyph stream byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the cell (even) |
| mem_wdata | output | 16 | Cell written |
| mem_rdata | input | 16 | Cell read, one cycle after read accept |

## Verification
The assertions rely on memory read data arriving exactly one cycle after each accepted read, and on `mem_ready` being driven from a register. The bench memory model registers its read data and toggles `mem_ready` from a free-running LFSR, so stalls come in varied patterns. The checks also assume every rectangle lies inside one display line and inside the modelled memory. Every bench command keeps its coordinates in bounds, with the copies at a stride that gives eight cells per line.

// File: rtl/cellblit_pkg.sv
package cellblit_pkg;
  localparam logic [1:0] OP_FILL = 2'd0;
  localparam logic [1:0] OP_STR  = 2'd1;
  localparam logic [1:0] OP_COPY = 2'd2;
  localparam logic [1:0] OP_NONE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_FETCH, ST_PUT, ST_RD, ST_RWAIT, ST_CPUT
  } blit_state_e;
endpackage

// File: rtl/cellblit_geom.sv
module cellblit_geom #(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int SW = 2,
  parameter int VW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] shift,
  input  logic [VW-1:0] vwidth,
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic          is_copy,
  output logic [AW-1:0] src_start,
  output logic [AW-1:0] dst_start,
  output logic [AW-1:0] col_step,
  output logic [AW-1:0] row_step
);
  logic [AW-1:0] cstride, rstride;
  logic [CW:0]   xadj, yadj, xs, ys, xd, yd;
  logic          fwd;

  always_comb begin
    cstride = AW'(2) << shift;
    rstride = cstride * AW'(vwidth >> 3);
    fwd = !is_copy || (sy > dy) || ((sy == dy) && (sx > dx));
    xadj = fwd ? '0 : ({1'b0, w} - (CW+1)'(1));
    yadj = fwd ? '0 : ({1'b0, h} - (CW+1)'(1));
    xs = {1'b0, sx} + xadj;
    ys = {1'b0, sy} + yadj;
    xd = {1'b0, dx} + xadj;
    yd = {1'b0, dy} + yadj;
    src_start = base + AW'(xs) * cstride + AW'(ys) * rstride;
    dst_start = base + AW'(xd) * cstride + AW'(yd) * rstride;
    col_step  = fwd ? cstride : (~cstride + AW'(1));
    row_step  = fwd ? rstride : (~rstride + AW'(1));
  end
endmodule

// File: rtl/cellblit_walker.sv
module cellblit_walker #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] col_step,
  input  logic [AW-1:0] row_step,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [CW-1:0] col_q, row_q;
  logic [AW-1:0] row_addr_q;
  logic          row_end;

  assign row_end = (col_q == width - CW'(1));
  assign last    = row_end && (row_q == height - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q      <= '0;
      row_q      <= '0;
      addr       <= '0;
      row_addr_q <= '0;
    end else if (load) begin
      col_q      <= '0;
      row_q      <= '0;
      addr       <= start_addr;
      row_addr_q <= start_addr;
    end else if (step) begin
      if (row_end) begin
        col_q      <= '0;
        row_q      <= row_q + CW'(1);
        row_addr_q <= row_addr_q + row_step;
        addr       <= row_addr_q + row_step;
      end else begin
        col_q <= col_q + CW'(1);
        addr  <= addr + col_step;
      end
    end
  end
endmodule

// File: rtl/cellblit_top.sv
module cellblit_top
  import cellblit_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int SW = 2,
  parameter int VW = 12,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [1:0]    cmd_op,
  input  logic [SW-1:0] cmd_shift,
  input  logic [VW-1:0] cmd_vwidth,
  input  logic [AW-1:0] cmd_base,
  input  logic [CW-1:0] cmd_sx,
  input  logic [CW-1:0] cmd_sy,
  input  logic [CW-1:0] cmd_dx,
  input  logic [CW-1:0] cmd_dy,
  input  logic [CW-1:0] cmd_width,
  input  logic [CW-1:0] cmd_height,
  input  logic [7:0]    cmd_glyph,
  input  logic [7:0]    cmd_fg,
  input  logic [7:0]    cmd_bg,
  input  logic [LW-1:0] cmd_len,
  input  logic          str_valid,
  output logic          str_ready,
  input  logic [7:0]    str_data,
  output logic          busy,
  output logic          done,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int NWALK = 2; // 0: destination, 1: source

  blit_state_e   st_q;
  logic [1:0]    op_q;
  logic [SW-1:0] shift_q;
  logic [VW-1:0] vw_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] sx_q, sy_q, dx_q, dy_q, w_q, h_q;
  logic [7:0]    glyph_q, attr_q;
  logic [LW-1:0] len_q, cnt_q;
  logic [15:0]   cell_q;
  logic          done_q;

  logic [AW-1:0] src_start, dst_start, col_step, row_step;
  logic [AW-1:0] w_addr  [NWALK];
  logic [AW-1:0] w_start [NWALK];
  logic          w_last  [NWALK];
  logic          w_step  [NWALK];
  logic          w_load;
  logic          zero_job, put_finish, accepted;

  cellblit_geom #(.AW(AW), .CW(CW), .SW(SW), .VW(VW)) u_geom (
    .base(base_q), .shift(shift_q), .vwidth(vw_q),
    .sx(sx_q), .sy(sy_q), .dx(dx_q), .dy(dy_q), .w(w_q), .h(h_q),
    .is_copy(op_q == OP_COPY),
    .src_start(src_start), .dst_start(dst_start),
    .col_step(col_step), .row_step(row_step)
  );

  assign w_start[0] = dst_start;
  assign w_start[1] = src_start;
  assign w_load     = (st_q == ST_SETUP);
  assign accepted   = mem_valid && mem_ready;
  assign w_step[0]  = accepted && mem_we;
  assign w_step[1]  = accepted && (st_q == ST_CPUT);

  for (genvar gi = 0; gi < NWALK; gi++) begin : g_walk
    cellblit_walker #(.AW(AW), .CW(CW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(w_load), .step(w_step[gi]),
      .start_addr(w_start[gi]), .col_step(col_step), .row_step(row_step),
      .width(w_q), .height(h_q), .addr(w_addr[gi]), .last(w_last[gi])
    );
  end

  assign zero_job = (w_q == '0) || (h_q == '0) || (op_q == OP_NONE) ||
                    ((op_q == OP_STR) && (len_q == '0));
  assign put_finish = w_last[0] ||
                      ((op_q == OP_STR) && (cnt_q == len_q - LW'(1)));

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign str_ready = (st_q == ST_FETCH);
  assign mem_valid = (st_q == ST_PUT) || (st_q == ST_RD) || (st_q == ST_CPUT);
  assign mem_we    = (st_q == ST_PUT) || (st_q == ST_CPUT);
  assign mem_addr  = (st_q == ST_RD) ? w_addr[1] : w_addr[0];
  assign mem_wdata = (st_q == ST_CPUT) ? cell_q : {attr_q, glyph_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      shift_q <= '0;
      vw_q    <= '0;
      base_q  <= '0;
      sx_q    <= '0;
      sy_q    <= '0;
      dx_q    <= '0;
      dy_q    <= '0;
      w_q     <= '0;
      h_q     <= '0;
      glyph_q <= '0;
      attr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      cell_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_start) begin
          op_q    <= cmd_op;
          shift_q <= cmd_shift;
          vw_q    <= cmd_vwidth;
          base_q  <= cmd_base;
          sx_q    <= cmd_sx;
          sy_q    <= cmd_sy;
          dx_q    <= cmd_dx;
          dy_q    <= cmd_dy;
          w_q     <= cmd_width;
          h_q     <= cmd_height;
          glyph_q <= cmd_glyph;
          attr_q  <= {cmd_bg[3:0], cmd_fg[3:0]};
          len_q   <= cmd_len;
          st_q    <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt_q <= '0;
          if (zero_job) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (op_q == OP_STR) st_q <= ST_FETCH;
          else if (op_q == OP_COPY)    st_q <= ST_RD;
          else                         st_q <= ST_PUT;
        end
        ST_FETCH: if (str_valid) begin
          glyph_q <= str_data;
          st_q    <= ST_PUT;
        end
        ST_PUT: if (mem_ready) begin
          cnt_q <= cnt_q + LW'(1);
          if (put_finish) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (op_q == OP_STR) st_q <= ST_FETCH;
        end
        ST_RD: if (mem_ready) st_q <= ST_RWAIT;
        ST_RWAIT: begin
          cell_q <= mem_rdata;
          st_q   <= ST_CPUT;
        end
        ST_CPUT: if (mem_ready) begin
          if (w_last[0]) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else st_q <= ST_RD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cellblit_chk.sv
module cellblit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic [1:0]    cmd_op,
  input logic          busy,
  input logic          done,
  input logic          str_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata
);
  logic copy_q, str_q, rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_q    <= 1'b0;
      str_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      if (cmd_start && !busy) begin
        copy_q <= (cmd_op == 2'd2);
        str_q  <= (cmd_op == 2'd1);
      end
      if (mem_valid && mem_ready) rd_pend_q <= !mem_we;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !str_ready); // R10
  AST_STREAM_STR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    str_ready |-> str_q); // R5
  AST_READ_COPY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we |-> copy_q && !rd_pend_q); // R8
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && copy_q |-> rd_pend_q); // R8
endmodule

bind cellblit_top cellblit_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_cellblit_top.sv
module tb_cellblit_top;
  localparam int AW = 16, CW = 8, SW = 2, VW = 12, LW = 10;
  localparam int BASE = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmd_start = 0;
  logic [1:0]    cmd_op = 0;
  logic [SW-1:0] cmd_shift = 0;
  logic [VW-1:0] cmd_vwidth = 64;
  logic [AW-1:0] cmd_base = BASE;
  logic [CW-1:0] cmd_sx = 0, cmd_sy = 0, cmd_dx = 0, cmd_dy = 0, cmd_width = 0, cmd_height = 0;
  logic [7:0]    cmd_glyph = 0, cmd_fg = 0, cmd_bg = 0;
  logic [LW-1:0] cmd_len = 0;
  logic          str_valid, str_ready;
  logic [7:0]    str_data;
  logic          busy, done, mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;

  cellblit_top #(.AW(AW), .CW(CW), .SW(SW), .VW(VW), .LW(LW)) dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] mem [0:1023];
  logic [15:0] refm [0:1023];
  logic [15:0] snap [0:1023];
  logic [7:0]  sbuf [0:63];
  logic [7:0]  lf;
  int rd_cnt = 0, wr_cnt = 0, consumed = 0, sbase = 0, savail = 0;
  int sidx;

  assign mem_ready = lf[0] | lf[3];
  assign sidx      = consumed - sbase;
  assign str_valid = (sidx < savail) && (lf[1] | lf[6]);
  assign str_data  = sbuf[sidx[5:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf <= 8'h5B;
    else lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[10:1]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[10:1]];
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (str_valid && str_ready) consumed <= consumed + 1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int cidx(input int sh, input int x, input int y);
    int cs = 2 << sh;
    return (BASE + x * cs + y * cs * (64 / 8)) >> 1;
  endfunction

  task automatic compare_mem(input string what);
    int bad = 0, first = -1;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== refm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(1'b1, what, 0, 0);
    else check(1'b0, {what, " word"}, int'(mem[first]), int'(refm[first]));
  endtask

  task automatic launch(input logic [1:0] op, input int sh, input int sx, input int sy,
                        input int dx, input int dy, input int w, input int h,
                        input int g, input int fg, input int bg, input int len);
    @(negedge clk);
    cmd_op = op; cmd_shift = SW'(sh); cmd_sx = CW'(sx); cmd_sy = CW'(sy);
    cmd_dx = CW'(dx); cmd_dy = CW'(dy); cmd_width = CW'(w); cmd_height = CW'(h);
    cmd_glyph = 8'(g); cmd_fg = 8'(fg); cmd_bg = 8'(bg); cmd_len = LW'(len);
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) return;
    end
  endtask

  task automatic t_reset();
    check(!busy && !done && !mem_valid && !str_ready, "R1 reset outputs idle",
          {busy, done, mem_valid, str_ready}, 0);
  endtask

  task automatic t_fill(input int sh, input int x, input int y, input int w, input int h,
                        input int g, input int fg, input int bg);
    launch(2'd0, sh, 0, 0, x, y, w, h, g, fg, bg, 0);
    wait_done();
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        refm[cidx(sh, x + c, y + r)] = {4'(bg), 4'(fg), 8'(g)};
    compare_mem("R2 R3 fill cells and attribute layout");
  endtask

  task automatic t_string(input int x, input int y, input int w, input int h, input int len);
    int n = (len < w * h) ? len : w * h;
    int c0 = consumed, w0 = wr_cnt;
    for (int i = 0; i < 64; i++) sbuf[i] = 8'(i * 13 + 7);
    sbase = consumed; savail = 40;
    launch(2'd1, 0, 0, 0, x, y, w, h, 0, 8'h9E, 8'h42, len);
    wait_done();
    @(negedge clk);
    for (int i = 0; i < n; i++)
      refm[cidx(0, x + i % w, y + i / w)] = {8'h2E, sbuf[i]};
    compare_mem("R4 string placement and early stop");
    check(consumed - c0 == n, "R5 stream bytes consumed", consumed - c0, n);
    check(wr_cnt - w0 == n, "R4 string write count", wr_cnt - w0, n);
    savail = 0;
  endtask

  task automatic t_copy(input string what, input int sx, input int sy, input int dx,
                        input int dy, input int w, input int h);
    int r0 = rd_cnt, w0 = wr_cnt;
    for (int i = 0; i < 1024; i++) snap[i] = refm[i];
    launch(2'd2, 0, sx, sy, dx, dy, w, h, 0, 0, 0, 0);
    wait_done();
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        refm[cidx(0, dx + c, dy + r)] = snap[cidx(0, sx + c, sy + r)];
    compare_mem(what);
    check(rd_cnt - r0 == w * h && wr_cnt - w0 == w * h, "R8 copy one read and write per cell",
          (rd_cnt - r0) * 1000 + (wr_cnt - w0), w * h * 1001);
  endtask

  task automatic t_zero(input string what, input logic [1:0] op, input int w, input int h);
    int a0 = rd_cnt + wr_cnt;
    bit seen = 0;
    launch(op, 0, 0, 0, 1, 1, w, h, 8'h77, 1, 2, 3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen && (rd_cnt + wr_cnt == a0), what, (rd_cnt + wr_cnt - a0) + (seen ? 0 : 256), 0);
  endtask

  task automatic t_busy();
    launch(2'd0, 0, 0, 0, 0, 8, 6, 4, 8'h31, 8'h04, 8'h05, 0);
    check(busy, "R9 busy after start", busy, 1);
    @(negedge clk); @(negedge clk);
    launch(2'd0, 0, 0, 0, 0, 14, 5, 2, 8'hEE, 8'h0F, 8'h0F, 0);
    wait_done();
    check(!busy, "R9 busy low with done", busy, 0);
    @(negedge clk);
    check(!done, "R9 done single cycle", done, 0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 6; c++)
        refm[cidx(0, c, 8 + r)] = 16'h5431;
    compare_mem("R9 start ignored while busy");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 16'(i * 37 + 5);
      refm[i] = 16'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fill(0, 1, 1, 3, 2, 8'h41, 8'hA5, 8'h3C);
    t_fill(1, 2, 3, 2, 3, 8'hC8, 8'h0E, 8'hF1);
    t_string(0, 16, 4, 3, 7);
    t_string(0, 20, 4, 3, 20);
    t_string(0, 24, 4, 3, 0);
    t_copy("R6 forward copy same row source right", 2, 1, 0, 1, 5, 2);
    t_copy("R6 forward copy source below", 1, 3, 1, 1, 4, 4);
    t_copy("R7 backward copy source above", 0, 0, 1, 1, 5, 3);
    t_copy("R7 backward copy same row source left", 0, 2, 2, 2, 6, 2);
    t_zero("R10 zero width no access", 2'd0, 0, 3);
    t_zero("R10 zero height no access", 2'd2, 3, 0);
    t_zero("R10 no-op command no access", 2'd3, 2, 2);
    t_busy();
    summary();
    $finish;
  end
endmodule